// File: doc/BRIEF.md
# Daisy-Chained SPI Position Readout

This block is a read-only SPI slave (clock idles low, data changes on the rising SCK edge, the master samples on the falling edge). It reports a 16-bit parallel value, such as an encoder position, to a host. Chip select is active low, and the block leaves both of its output drivers off while it is deselected. On the first rising SCK edge after select, the whole parallel value is captured in one system-clock cycle. It is then shifted out MSB first on the MISO pin over 16 SCK cycles.

Several devices share one chip select and one SCK. Each device's chain output is tied to the bus together with its MISO pin, and its chain input takes the serial data of the next device along the chain. While a device sends its own word, a 16-stage delay line collects the upstream bits. From the 17th rising edge on, the device turns off its MISO driver, turns on its chain driver, and passes the upstream stream through 16 bits late. The host therefore reads every device's word back to back, and all words were captured on the same first SCK edge.

SCK, chip select and the chain input are brought into the system clock domain through a synchronizer of SYNC_STAGES flops. All shifting happens at system-clock edges. The clock of the logic that produces the parallel value is never gated.

Top module: `spi_daisy_readout`

## Requirements
- R1: While the synchronized chip select is high, miso_oe_o and chain_oe_o are both low.
- R2: After reset, both output enables and both data outputs are low.
- R3: On the first synchronized rising SCK edge after select, all 16 bits of value_i are taken from the same system-clock cycle, and bit 15 of that value appears on the data outputs.
- R4: On rising edges 2 to 16 the data outputs present bits 14 down to 0 of the captured value, one bit per edge. During this time miso_oe_o is high and chain_oe_o is low.
- R5: On the 17th rising edge miso_oe_o falls and chain_oe_o rises. The two enables are never high together.
- R6: From the 17th rising edge on, the bit presented at rising edge 16+j equals chain_i as sampled at falling edge j. This passes the upstream stream through 16 bits late, for any transaction length.
- R7: Deselecting ends the transaction. The edge counter, the handover bit and the delay line are cleared, so the next select starts again from the device's own word.
- R8: SCK edges that arrive while the device is deselected have no effect on the outputs or on the next transaction.
- R9: An SCK edge acts on the data outputs SYNC_STAGES+1 system clocks after it reaches sck_i, and nothing changes them between edges. The output enables follow cs_ni after SYNC_STAGES clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI serial clock, idles low |
| chain_i | input | 1 | Serial data from the upstream device |
| value_i | input | 16 | Parallel value to report |
| miso_o | output | 1 | Serial data for the own word |
| miso_oe_o | output | 1 | Driver enable for miso_o |
| chain_o | output | 1 | Serial data forwarded from upstream |
| chain_oe_o | output | 1 | Driver enable for chain_o |

## Verification
Every input passes through SYNC_STAGES flops before the logic uses it. A data result is therefore due SYNC_STAGES+1 clocks after its SCK edge, and an enable change is due SYNC_STAGES clocks after its chip-select change. The bench model keeps a history of input samples taken at each rising clock edge. It applies each edge at exactly that depth and compares all four outputs at every falling clock edge, where they are stable. At the transaction level, the bench acts as both the host and the upstream device. It holds each SCK phase for six clocks, far longer than the synchronizer latency, and reads the bus just before each falling SCK edge. This checks the captured word and the 16-bit pass-through independently of the clock-level timing.

// File: rtl/spi_daisy_pkg.sv
package spi_daisy_pkg;
  localparam int unsigned WORD_W_DEF = 16;
  localparam int unsigned SYNC_DEF   = 2;

  // bit positions of the synchronized input bundle
  localparam int unsigned IN_CHAIN = 0;
  localparam int unsigned IN_SCK   = 1;
  localparam int unsigned IN_CS    = 2;
  localparam int unsigned IN_W     = 3;

  typedef struct packed {
    logic rise;
    logic fall;
  } sck_edge_t;
endpackage

// File: rtl/sdr_sync.sv
module sdr_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RESET_VAL;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RESET_VAL;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdr_edge.sv
module sdr_edge
  import spi_daisy_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      sck_s_i,
  output sck_edge_t edge_o
);
  logic sck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= sck_s_i;
  end

  assign edge_o.rise = sck_s_i & ~sck_d_q;
  assign edge_o.fall = ~sck_s_i & sck_d_q;
endmodule

// File: rtl/sdr_word_shift.sv
module sdr_word_shift #(
  parameter int unsigned W  = 16,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rise_i,
  input  logic [W-1:0]  value_i,
  output logic          bit_o,
  output logic          first_o,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  assign first_o = (cnt_q == '0);
  assign done_o  = (cnt_q == CW'(W));
  assign cnt_o   = cnt_q;
  // first edge: bit comes straight from the parallel value, rest is parked
  assign bit_o   = first_o ? value_i[W-1] : sh_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (rise_i) begin
      if (first_o) begin
        sh_q <= {value_i[W-2:0], 1'b0};
      end else if (!done_o) begin
        sh_q <= {sh_q[W-2:0], 1'b0};
      end
      if (!done_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdr_delay_line.sv
module sdr_delay_line #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic shift_i,
  input  logic d_i,
  output logic head_o
);
  logic [DEPTH-1:0] dly_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      dly_q[i] <= 1'b0;
      else if (clr_i)   dly_q[i] <= 1'b0;
      else if (shift_i) dly_q[i] <= (i == 0) ? d_i : dly_q[(i == 0) ? 0 : i-1];
    end
  end

  assign head_o = dly_q[DEPTH-1];
endmodule

// File: rtl/spi_daisy_readout.sv
module spi_daisy_readout
  import spi_daisy_pkg::*;
#(
  parameter int unsigned WORD_W      = WORD_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              chain_i,
  input  logic [WORD_W-1:0] value_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              chain_o,
  output logic              chain_oe_o
);
  localparam int unsigned CW = $clog2(WORD_W + 1);
  localparam logic [IN_W-1:0] IN_RST = IN_W'(1) << IN_CS;

  logic [IN_W-1:0] in_raw, in_s;
  sck_edge_t       sck_edge;
  logic            active, clr;
  logic            own_bit, own_first, own_done;
  logic [CW-1:0]   own_cnt;
  logic            dly_head;
  logic            pass_q, data_q;

  assign in_raw = {cs_ni, sck_i, chain_i};

  sdr_sync #(
    .WIDTH(IN_W), .STAGES(SYNC_STAGES), .RESET_VAL(IN_RST)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(in_raw), .q_o(in_s)
  );

  sdr_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .sck_s_i(in_s[IN_SCK]), .edge_o(sck_edge)
  );

  assign active = ~in_s[IN_CS];
  assign clr    = ~active;

  sdr_word_shift #(.W(WORD_W)) u_word (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .rise_i(sck_edge.rise),
    .value_i(value_i), .bit_o(own_bit), .first_o(own_first),
    .done_o(own_done), .cnt_o(own_cnt)
  );

  // upstream data is stable around the falling edge, sample it there
  sdr_delay_line #(.DEPTH(WORD_W)) u_dly (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .shift_i(sck_edge.fall),
    .d_i(in_s[IN_CHAIN]), .head_o(dly_head)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pass_q <= 1'b0;
      data_q <= 1'b0;
    end else if (clr) begin
      pass_q <= 1'b0;
      data_q <= 1'b0;
    end else if (sck_edge.rise) begin
      if (pass_q || own_done) begin
        pass_q <= 1'b1;
        data_q <= dly_head;
      end else begin
        data_q <= own_bit;
      end
    end
  end

  assign miso_o     = data_q;
  assign chain_o    = data_q;
  assign miso_oe_o  = active & ~pass_q;
  assign chain_oe_o = active & pass_q;
endmodule

// File: rtl/spi_daisy_readout_chk.sv
module spi_daisy_readout_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          active,
  input logic          rise,
  input logic          first,
  input logic [CW-1:0] cnt,
  input logic [W-1:0]  value_i,
  input logic          data,
  input logic          miso_oe,
  input logic          chain_oe
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (!miso_oe && !chain_oe));

  p_latch_msb_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && rise && first) |=> (data == $past(value_i[W-1])));

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(W));

  p_oe_exclusive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({miso_oe, chain_oe}));

  p_handover_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(chain_oe) |-> (cnt == CW'(W)));

  p_hold_between_edges_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !rise) |=> $stable(data));
endmodule

bind spi_daisy_readout spi_daisy_readout_chk #(.W(WORD_W), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .active(active), .rise(sck_edge.rise),
  .first(own_first), .cnt(own_cnt), .value_i(value_i), .data(data_q),
  .miso_oe(miso_oe_o), .chain_oe(chain_oe_o)
);

// File: tb/spi_daisy_readout_tb.sv
module spi_daisy_readout_tb;
  localparam int W = 16;
  localparam int N = 2;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, chain = 1'b0;
  logic [W-1:0] value = '0;
  logic miso, miso_oe, chain_o, chain_oe;
  logic churn = 1'b0;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  spi_daisy_readout u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .chain_i(chain),
    .value_i(value), .miso_o(miso), .miso_oe_o(miso_oe),
    .chain_o(chain_o), .chain_oe_o(chain_oe)
  );

  // reference model: history of input samples, one per rising clock edge
  logic h_cs [0:N+1];
  logic h_sck [0:N+1];
  logic h_ch [0:N+1];
  int m_idx;
  logic m_pass, m_data;
  logic [W-1:0] m_word;
  logic m_q [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= N+1; i++) begin
        h_cs[i] = 1'b1; h_sck[i] = 1'b0; h_ch[i] = 1'b0;
      end
      m_idx = 0; m_pass = 0; m_data = 0; m_word = '0; m_q.delete();
    end else begin
      for (int i = N+1; i > 0; i--) begin
        h_cs[i] = h_cs[i-1]; h_sck[i] = h_sck[i-1]; h_ch[i] = h_ch[i-1];
      end
      h_cs[0] = cs_n; h_sck[0] = sck; h_ch[0] = chain;
      if (h_cs[N]) begin
        m_idx = 0; m_pass = 0; m_data = 0; m_q.delete();
      end else begin
        if (h_sck[N] && !h_sck[N+1]) begin
          if (m_idx == 0) begin
            m_word = value; m_data = value[W-1]; m_idx = 1;
          end else if (m_idx < W) begin
            m_data = m_word[W-1-m_idx]; m_idx++;
          end else begin
            m_pass = 1; m_data = (m_q.size() >= W) ? m_q[0] : 1'b0;
          end
        end
        if (!h_sck[N] && h_sck[N+1]) begin
          m_q.push_back(h_ch[N]);
          if (m_q.size() > W) void'(m_q.pop_front());
        end
      end
    end
  end

  // R9: every output compared against the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_moe, e_coe;
      e_moe = !h_cs[N-1] && !m_pass;
      e_coe = !h_cs[N-1] && m_pass;
      checks++;
      if (miso_oe !== e_moe || chain_oe !== e_coe || miso !== m_data || chain_o !== m_data) begin
        failures++;
        $display("FAIL R9 cycle: oe=%b%b data=%b%b exp oe=%b%b data=%b",
                 miso_oe, chain_oe, miso, chain_o, e_moe, e_coe, m_data);
      end
    end
  end

  always @(negedge clk) if (churn) value <= value + 16'h0123;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int nbits, input logic [63:0] up, output logic [63:0] got);
    got = '0;
    cs_n = 1'b0;
    ticks(HALF);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b1;
      chain = up[63-i];
      ticks(HALF);
      got[63-i] = miso_oe ? miso : (chain_oe ? chain_o : 1'bx);
      if (i == W-1) check("R4 own enable", {62'd0, miso_oe, chain_oe}, 64'd2);
      if (i == W)   check("R5 handover enable", {62'd0, miso_oe, chain_oe}, 64'd1);
      sck = 1'b0;
      ticks(HALF);
    end
    cs_n = 1'b1;
    ticks(N + 2);
    check("R1 deselect quiet", {62'd0, miso_oe, chain_oe}, 64'd0);
    ticks(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] got, up;
    ticks(3);
    check("R2 reset", {60'd0, miso, miso_oe, chain_o, chain_oe}, 64'd0);
    rst_n = 1'b1;
    ticks(4);
    check("R2 after reset", {60'd0, miso, miso_oe, chain_o, chain_oe}, 64'd0);

    // own word plus one upstream word
    value = 16'hA5C3;
    up = {16'h1234, 48'h0};
    xfer(32, up, got);
    check("R3 R4 own word", {48'd0, got[63:48]}, {48'd0, 16'hA5C3});
    check("R6 forwarded word", {48'd0, got[47:32]}, {48'd0, 16'h1234});

    // R8: SCK toggling while deselected
    value = 16'h0F0F;
    for (int i = 0; i < 5; i++) begin
      sck = 1'b1; ticks(HALF);
      check("R8 ignored edge", {62'd0, miso_oe, chain_oe}, 64'd0);
      sck = 1'b0; ticks(HALF);
    end
    up = {16'hFFFF, 16'h8001, 32'h0};
    xfer(48, up, got);
    check("R8 R3 word after idle edges", {48'd0, got[63:48]}, {48'd0, 16'h0F0F});
    check("R6 two upstream words", {32'd0, got[47:16]}, {32'd0, 16'hFFFF, 16'h8001});

    // R7: abort after five bits, next select restarts with own word
    value = 16'h7E81;
    xfer(5, 64'hFFFF_FFFF_FFFF_FFFF, got);
    check("R7 partial word", {59'd0, got[63:59]}, {59'd0, 5'b01111});
    value = 16'h3C5A;
    xfer(17, 64'h0, got);
    check("R7 restart own word", {48'd0, got[63:48]}, {48'd0, 16'h3C5A});
    check("R7 delay line cleared", {63'd0, got[47]}, 64'd0);

    // R3: value changing every clock, capture must come from one cycle
    churn = 1'b1;
    xfer(16, 64'h0, got);
    churn = 1'b0;
    check("R3 no tearing", {48'd0, got[63:48]}, {48'd0, m_word});

    // R4: extremes of the own word
    value = 16'h0001;
    xfer(16, 64'h0, got);
    check("R4 lsb only", {48'd0, got[63:48]}, 64'h0001);
    value = 16'h8000;
    xfer(16, 64'h0, got);
    check("R4 msb only", {48'd0, got[63:48]}, 64'h8000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule